// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This block is a memory-mapped doorbell between application processors and a system control processor. It has two one-way channels. The inbound channel carries doorbells from the control processor to the application processors. The outbound channel carries doorbells from the application processors to the control processor. Each channel keeps a 32-bit status word. Bits 30:0 are message slots. Bit 31 is a sticky flag that records a non-secure attempt to touch that channel.

Software reaches each channel through three words. A read-only status word shows the current slots and the flag. A write-one-to-set alias raises slots. A write-one-to-clear alias lowers slots or the flag. A sender posts a command by setting a slot in the outbound direction. While that slot stays set, the previous command has not been consumed. The receiver clears the slot once it has handled the command. Each channel drives a level interrupt toward its receiver while any slot is pending.

The bus port accepts one access per cycle and completes it in that cycle. Read data is combinational from the request and the current status. Every access carries a secure attribute. Non-secure accesses never see or alter the slots.

Top module: `dbell_mailbox`

## Requirements
- R1: The inbound channel answers at offsets 0x200 (status), 0x208 (set) and 0x210 (clear). The outbound channel answers at 0x300 (status), 0x308 (set) and 0x310 (clear).
- R2: A secure write to a set alias raises every status slot among bits 30:0 whose write-data bit is one. Slots written with zero keep their value.
- R3: A secure write to a clear alias lowers every status bit whose write-data bit is one. Bits written with zero keep their value.
- R4: After reset, both status words read zero and both interrupts are low.
- R5: Each interrupt is high exactly when one of bits 30:0 of its channel's status is set. Bit 31 has no effect on the interrupt. `irq_app` follows the inbound channel and `irq_ctl` follows the outbound channel.
- R6: A non-secure access to any of a channel's three offsets sets bit 31 of that channel and leaves bits 30:0 of both channels unchanged. A non-secure read returns zero.
- R7: Bit 31 is lowered only by a secure write of a one in bit 31 to the clear alias. A one in bit 31 written to the set alias is ignored, and clearing slots leaves bit 31 alone.
- R8: The following return zero and change no status: reads of the set and clear aliases, any access to an unmapped offset, and writes to a status offset.
- R9: The two channels are independent. An access to one channel never changes the other channel's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_secure | input | 1 | 1 for a secure access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_app | output | 1 | Inbound channel interrupt toward the application processors |
| irq_ctl | output | 1 | Outbound channel interrupt toward the control processor |

## Verification
The assertions check these rules on every cycle:
- a set write raises its slots and leaves the flag alone;
- a clear write lowers the addressed bits;
- a non-secure access raises the flag without disturbing any slot;
- a cycle with no write of the channel's own leaves its status unchanged;
- read data is zero for everything except a secure status read.

Only the bench's scenarios show the rest:
- the exact offset map;
- the reset contents;
- the interrupt level as slots come and go;
- the order of flag clearing against slot clearing;
- the isolation between the two channels.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    typedef enum logic [1:0] {
        ALIAS_STAT = 2'd0,
        ALIAS_SET  = 2'd1,
        ALIAS_CLR  = 2'd2,
        ALIAS_NONE = 2'd3
    } dbell_alias_e;

    typedef struct packed {
        logic ns_touch;
        logic rd_stat;
        logic wr_set;
        logic wr_clr;
    } dbell_dec_t;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] BASE    = 12'h200,
    parameter logic [ADDR_W-1:0] SET_OFS = 12'h008,
    parameter logic [ADDR_W-1:0] CLR_OFS = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic              secure,
    input  logic [ADDR_W-1:0] addr,
    output dbell_dec_t        dec
);
    localparam logic [ADDR_W-1:0] SET_ADDR = BASE + SET_OFS;
    localparam logic [ADDR_W-1:0] CLR_ADDR = BASE + CLR_OFS;

    dbell_alias_e alias_kind;

    always_comb begin
        if (addr == BASE)          alias_kind = ALIAS_STAT;
        else if (addr == SET_ADDR) alias_kind = ALIAS_SET;
        else if (addr == CLR_ADDR) alias_kind = ALIAS_CLR;
        else                       alias_kind = ALIAS_NONE;
    end

    always_comb begin
        dec = '0;
        if (valid) begin
            unique case (alias_kind)
                ALIAS_STAT: begin
                    dec.ns_touch = !secure;
                    dec.rd_stat  = secure && !write;
                end
                ALIAS_SET: begin
                    dec.ns_touch = !secure;
                    dec.wr_set   = secure && write;
                end
                ALIAS_CLR: begin
                    dec.ns_touch = !secure;
                    dec.wr_clr   = secure && write;
                end
                ALIAS_NONE: dec = '0;
            endcase
        end
    end

    assert_dec_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.ns_touch, dec.rd_stat, dec.wr_set, dec.wr_clr}));

endmodule

// File: rtl/dbell_channel.sv
module dbell_channel
    import dbell_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbell_dec_t        dec,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    localparam int FLAG = DATA_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (dec.ns_touch) begin
            status[FLAG] <= 1'b1;
        end else if (dec.wr_set) begin
            status[FLAG-1:0] <= status[FLAG-1:0] | wdata[FLAG-1:0];
        end else if (dec.wr_clr) begin
            status <= status & ~wdata;
        end
    end

    always_comb irq = |status[FLAG-1:0];

    assert_set_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr_set |=> ((status[FLAG-1:0] & $past(wdata[FLAG-1:0])) == $past(wdata[FLAG-1:0])));

    assert_clr_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr_clr |=> ((status & $past(wdata)) == '0));

    assert_ns_flag_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec.ns_touch |=> (status[FLAG] && status[FLAG-1:0] == $past(status[FLAG-1:0])));

    assert_set_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr_set |=> (status[FLAG] == $past(status[FLAG])));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.ns_touch || dec.wr_set || dec.wr_clr) |=> $stable(status));

endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] IN_BASE  = 12'h200,
    parameter logic [ADDR_W-1:0] OUT_BASE = 12'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_secure,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_app,
    output logic              irq_ctl
);
    localparam int NCH = 2;

    dbell_dec_t        dec    [NCH];
    logic [DATA_W-1:0] status [NCH];
    logic [NCH-1:0]    irq_v;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_BASE = (ch == 0) ? IN_BASE : OUT_BASE;

        dbell_decode #(
            .ADDR_W (ADDR_W),
            .BASE   (CH_BASE)
        ) u_dec (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid  (bus_valid),
            .write  (bus_write),
            .secure (bus_secure),
            .addr   (bus_addr),
            .dec    (dec[ch])
        );

        dbell_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .dec    (dec[ch]),
            .wdata  (bus_wdata),
            .status (status[ch]),
            .irq    (irq_v[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (dec[ch].rd_stat) bus_rdata = bus_rdata | status[ch];
        end
    end

    assign irq_app = irq_v[0];
    assign irq_ctl = irq_v[1];

    assert_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || bus_write || !bus_secure) |-> (bus_rdata == '0));

    assert_set_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec[1].wr_set && |bus_wdata[DATA_W-2:0]) |=> irq_ctl);

endmodule

// File: tb/dbell_mailbox_tb.sv
module dbell_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_secure = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_app;
    logic        irq_ctl;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbell_mailbox u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_secure (bus_secure),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_app    (irq_app),
        .irq_ctl    (irq_ctl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_secure = sec; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic sec, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_secure = sec; bus_addr = a; bus_wdata = '0;
        #1;
        chk(tag, bus_rdata, exp);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic irqs(input logic ea, input logic ec, input string tag);
        @(negedge clk);
        #1;
        chk({tag, " irq_app"}, {31'd0, irq_app}, {31'd0, ea});
        chk({tag, " irq_ctl"}, {31'd0, irq_ctl}, {31'd0, ec});
    endtask

    task automatic t_reset;
        rd(12'h200, 1'b1, 32'h0, "R4 inbound status");
        rd(12'h300, 1'b1, 32'h0, "R4 outbound status");
        irqs(1'b0, 1'b0, "R4");
    endtask

    task automatic t_set;
        wr(12'h308, 32'h0000_0005, 1'b1);
        rd(12'h300, 1'b1, 32'h0000_0005, "R2 set outbound");
        irqs(1'b0, 1'b1, "R5 R9 outbound only");
        rd(12'h200, 1'b1, 32'h0, "R9 inbound untouched");
        wr(12'h308, 32'h0, 1'b1);
        rd(12'h300, 1'b1, 32'h0000_0005, "R2 zero write keeps");
        wr(12'h208, 32'h4000_0000, 1'b1);
        rd(12'h200, 1'b1, 32'h4000_0000, "R1 inbound slot 30");
        irqs(1'b1, 1'b1, "R5 both");
    endtask

    task automatic t_clear;
        wr(12'h310, 32'h0000_0001, 1'b1);
        rd(12'h300, 1'b1, 32'h0000_0004, "R3 clear slot 0");
        wr(12'h310, 32'h0, 1'b1);
        rd(12'h300, 1'b1, 32'h0000_0004, "R3 zero clear keeps");
        wr(12'h310, 32'h0000_0004, 1'b1);
        rd(12'h300, 1'b1, 32'h0, "R3 clear slot 2");
        irqs(1'b1, 1'b0, "R5 outbound drained");
    endtask

    task automatic t_nonsecure;
        wr(12'h308, 32'h0000_00FF, 1'b0);
        rd(12'h300, 1'b1, 32'h8000_0000, "R6 ns write flags only");
        irqs(1'b1, 1'b0, "R5 flag no irq");
        rd(12'h200, 1'b0, 32'h0, "R6 ns read zero");
        rd(12'h200, 1'b1, 32'hC000_0000, "R6 ns read flags inbound");
    endtask

    task automatic t_flag;
        wr(12'h208, 32'h8000_0000, 1'b1);
        rd(12'h200, 1'b1, 32'hC000_0000, "R7 set ignores bit31");
        wr(12'h210, 32'h4000_0000, 1'b1);
        rd(12'h200, 1'b1, 32'h8000_0000, "R7 slot clear keeps flag");
        irqs(1'b0, 1'b0, "R5 flag only");
        wr(12'h210, 32'h8000_0000, 1'b1);
        rd(12'h200, 1'b1, 32'h0, "R7 flag cleared");
        wr(12'h310, 32'h8000_0000, 1'b1);
        rd(12'h300, 1'b1, 32'h0, "R7 outbound flag cleared");
    endtask

    task automatic t_alias;
        wr(12'h308, 32'h0000_0003, 1'b1);
        rd(12'h308, 1'b1, 32'h0, "R8 set alias reads zero");
        rd(12'h310, 1'b1, 32'h0, "R8 clear alias reads zero");
        rd(12'h304, 1'b1, 32'h0, "R8 unmapped reads zero");
        wr(12'h300, 32'h0, 1'b1);
        rd(12'h300, 1'b1, 32'h0000_0003, "R8 status write ignored");
        wr(12'h000, 32'hFFFF_FFFF, 1'b0);
        wr(12'h314, 32'hFFFF_FFFF, 1'b1);
        rd(12'h300, 1'b1, 32'h0000_0003, "R8 unmapped no effect outbound");
        rd(12'h200, 1'b1, 32'h0, "R8 unmapped no effect inbound");
        wr(12'h310, 32'h0000_0003, 1'b1);
        irqs(1'b0, 1'b0, "R1 R5 final");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_clear();
        t_nonsecure();
        t_flag();
        t_alias();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule